// File: doc/BRIEF.md
# Eight-Bit Timer with Compare-Driven Output

This block is an 8-bit up-counter that advances on each cycle in which its tick input (a clock enable) is high. It has one compare register and one waveform output. Two counting behaviours are available: a free-running count that wraps from 0xFF to 0x00, and a clear-on-compare count in which the compare value acts as the top of the count. Each real compare match sets a sticky flag and drives the waveform output. The output can toggle, go low, go high, or do nothing.

Software uses a register port with a single-cycle write strobe and a combinational read mux. Through it, software can load the counter, set the compare value, choose the counting and output modes, clear the two status flags by writing ones, and fire a force strobe. The force strobe applies the output action at once, with no real match.

A counter load from software is handled by a two-state control machine. The state CNT_RUN is left for CNT_RELOAD on any counter write. The machine stays in CNT_RELOAD while writes continue. It returns to CNT_RUN on the first tick with no write, and a compare match is masked on that tick. A new output-mode setting takes effect only at a compare match. At each real match it is copied into an active copy, and the force strobe acts on that active copy.

Top module: `tmr8_cmp`

Register map (address: content). 0: counter. 1: compare value. 2: control, with bits 1:0 as the counting mode and bits 3:2 as the output mode. 3: force strobe, applied when bit 0 of the written data is 1; reads as 0. 4: flags, with bit 0 = overflow and bit 1 = compare match; writing a 1 to a bit clears it.

## Requirements
- R1: After reset, the counter, compare value, control register, both flags and the waveform output are all 0.
- R2: The counter changes only on a tick or a counter write. With neither, it holds its value.
- R3: In counting mode 0, and in the reserved modes 1 and 3, the counter increments by one on each tick and wraps from 0xFF to 0x00. It is never cleared on a match.
- R4: In counting mode 2, a tick with the counter equal to the compare value loads 0 into the counter instead of incrementing it.
- R5: A tick with the counter at 0xFF and no counter write sets the overflow flag (flag bit 0). Only a write of 1 to bit 0 of the flag register clears it. If a set and a clear fall in the same cycle, the set wins.
- R6: A real compare match sets the compare flag (flag bit 1). Only a write of 1 to bit 1 of the flag register clears it.
- R7: On a compare match, the output action is chosen by control bits 3:2: 0 holds the output, 1 toggles it, 2 drives it to 0, and 3 drives it to 1.
- R8: A new output-mode value is first used at the next real compare match. Until that match, the force strobe still applies the previous setting (0 after reset).
- R9: A force strobe applies the active output action on the next clock edge. It sets no flag and does not change the counter.
- R10: A counter write takes priority over a tick in the same cycle, and that tick sets no overflow flag. The first tick after a counter write cannot produce a compare match.
- R11: The output-mode bits do not change the counting sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wave_out | output | 1 | Compare-driven waveform output |

## Verification
The checker tests the following on every cycle:
- the counter holds when it has neither a tick nor a write;
- the counter steps by one in free-running mode, and clears on a match in clear-on-compare mode;
- a counter write loads its value;
- the overflow flag rises after a tick at 0xFF;
- the output holds when it has neither a match nor a force.

Some behaviours only the directed scenarios can show. These are the delayed adoption of a new output mode against a force strobe, the masked match after a counter load, the write-one-to-clear rules of the flags with set winning, and each of the four output actions.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_FORCE = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

    typedef enum logic [1:0] {
        OC_HOLD   = 2'd0,
        OC_TOGGLE = 2'd1,
        OC_CLEAR  = 2'd2,
        OC_SET    = 2'd3
    } oc_act_e;

    localparam logic [1:0] MODE_CTC = 2'd2;

    typedef enum logic {
        CNT_RUN    = 1'b0,
        CNT_RELOAD = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/tmr8_count.sv
module tmr8_count
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         ctc_en,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt_q,
    output logic         match_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    cnt_state_e state_q, state_d;
    logic [W-1:0] cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_RUN:    if (ld_en) state_d = CNT_RELOAD;
            CNT_RELOAD: if (!ld_en && tick) state_d = CNT_RUN;
        endcase
    end

    // outputs of the step
    always_comb begin
        match_o = tick && !ld_en && (state_q == CNT_RUN) && (cnt_q == cmp_val);
        wrap_o  = tick && !ld_en && (cnt_q == CNT_MAX);
        if (ld_en)                  cnt_d = ld_val;
        else if (!tick)             cnt_d = cnt_q;
        else if (ctc_en && match_o) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic       force_cmp,
    input  logic [1:0] oc_sel,
    output logic       wave_q
);
    oc_act_e act_q;
    oc_act_e act_use;
    logic    wave_d;

    always_comb begin
        act_use = match ? oc_act_e'(oc_sel) : act_q;
        wave_d  = wave_q;
        if (match || force_cmp) begin
            unique case (act_use)
                OC_HOLD:   wave_d = wave_q;
                OC_TOGGLE: wave_d = ~wave_q;
                OC_CLEAR:  wave_d = 1'b0;
                OC_SET:    wave_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= OC_HOLD;
            wave_q <= 1'b0;
        end else begin
            if (match) act_q <= oc_act_e'(oc_sel);
            wave_q <= wave_d;
        end
    end
endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              wave_out
);
    logic [W-1:0] cmp_q;
    logic [1:0]   mode_q;
    logic [1:0]   oc_q;
    logic         ovf_q, cmpf_q;
    logic [W-1:0] cnt_q;
    logic         match, wrap, ld_cnt, force_cmp, flag_wr;

    assign ld_cnt    = wr_en && (wr_addr == A_COUNT);
    assign force_cmp = wr_en && (wr_addr == A_FORCE) && wr_data[0];
    assign flag_wr   = wr_en && (wr_addr == A_FLAGS);

    tmr8_count #(.W(W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ld_en  (ld_cnt),
        .ld_val (wr_data),
        .ctc_en (mode_q == MODE_CTC),
        .cmp_val(cmp_q),
        .cnt_q  (cnt_q),
        .match_o(match),
        .wrap_o (wrap)
    );

    tmr8_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .force_cmp(force_cmp),
        .oc_sel   (oc_q),
        .wave_q   (wave_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= '0;
            oc_q   <= '0;
            ovf_q  <= 1'b0;
            cmpf_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_CMP) cmp_q <= wr_data;
            if (wr_en && wr_addr == A_CTRL) begin
                mode_q <= wr_data[1:0];
                oc_q   <= wr_data[3:2];
            end
            ovf_q  <= wrap  | (ovf_q  & ~(flag_wr & wr_data[0]));
            cmpf_q <= match | (cmpf_q & ~(flag_wr & wr_data[1]));
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_COUNT: rd_data = cnt_q;
            A_CMP:   rd_data = cmp_q;
            A_CTRL:  rd_data[3:0] = {oc_q, mode_q};
            A_FLAGS: rd_data[1:0] = {cmpf_q, ovf_q};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      cnt_q,
    input logic [W-1:0]      cmp_q,
    input logic [1:0]        mode_q,
    input logic              ovf_q,
    input logic              wave_out
);
    logic ld, frc;
    assign ld  = wr_en && (wr_addr == A_COUNT);
    assign frc = wr_en && (wr_addr == A_FORCE) && wr_data[0];

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cnt_q));                                        // R2
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && mode_q != MODE_CTC) |=> (cnt_q == $past(cnt_q) + 1'b1));    // R3
    AST_CTC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && mode_q == MODE_CTC && cnt_q != cmp_q) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_q == $past(wr_data)));                                          // R10
    AST_OVF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt_q == {W{1'b1}}) |=> ovf_q);                             // R5
    AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !frc) |=> $stable(wave_out));                                     // R9
endmodule

bind tmr8_cmp tmr8_cmp_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .cmp_q   (cmp_q),
    .mode_q  (mode_q),
    .ovf_q   (ovf_q),
    .wave_out(wave_out)
);

// File: tb/tmr8_cmp_tb.sv
module tmr8_cmp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wave_out;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    tmr8_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wave_out(wave_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hard_reset();
        rd(3'd0, v); chk("R1 count", v, 0);
        rd(3'd1, v); chk("R1 compare", v, 0);
        rd(3'd2, v); chk("R1 control", v, 0);
        rd(3'd4, v); chk("R1 flags", v, 0);
        chk("R1 wave", wave_out, 0);
    endtask

    task automatic t_tick_gate();
        logic [7:0] v;
        wr(3'd0, 8'd10);
        repeat (4) @(negedge clk);
        rd(3'd0, v); chk("R2 hold without tick", v, 10);
        ticks(5);
        rd(3'd0, v); chk("R2 five ticks", v, 15);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr(3'd4, 8'h03);
        wr(3'd0, 8'hFD);
        ticks(3);
        rd(3'd0, v); chk("R3 wrap to zero", v, 0);
        rd(3'd4, v); chk("R5 overflow set", v[0], 1);
        ticks(4);
        rd(3'd4, v); chk("R5 overflow sticky", v[0], 1);
        wr(3'd4, 8'h02);
        rd(3'd4, v); chk("R5 clear other bit keeps overflow", v[0], 1);
        chk("R6 compare flag cleared", v[1], 0);
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R5 overflow cleared", v[0], 0);
        wr(3'd2, 8'h03);                         // reserved mode 3
        wr(3'd1, 8'h10);
        wr(3'd0, 8'h0E);
        ticks(4);
        rd(3'd0, v); chk("R3 reserved mode not cleared at compare", v, 8'h12);
        wr(3'd2, 8'h01);                         // reserved mode 1
        wr(3'd0, 8'hFF);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(3'd0, v); chk("R3 reserved mode wraps", v, 0);
        rd(3'd4, v); chk("R5 set beats clear", v[0], 1);
    endtask

    task automatic t_ctc();
        logic [7:0] v;
        wr(3'd2, 8'h02);
        wr(3'd1, 8'd5);
        wr(3'd4, 8'h03);
        wr(3'd0, 8'd0);
        ticks(6);
        rd(3'd0, v); chk("R4 clear at compare", v, 0);
        rd(3'd4, v); chk("R6 compare flag set", v[1], 1);
        ticks(3);
        rd(3'd0, v); chk("R4 restart after clear", v, 3);
        wr(3'd4, 8'h03);
        wr(3'd0, 8'd5);
        ticks(1);
        rd(3'd0, v); chk("R10 match masked after load", v, 6);
        rd(3'd4, v); chk("R10 no flag on masked match", v[1], 0);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h40;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(3'd0, v); chk("R10 write beats tick", v, 8'h40);
        wr(3'd0, 8'hFF);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h20;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(3'd4, v); chk("R10 no overflow on write cycle", v[0], 0);
    endtask

    task automatic t_wave();
        logic [7:0] v;
        hard_reset();
        wr(3'd1, 8'd3);
        wr(3'd2, 8'h06);                          // CTC, toggle
        wr(3'd3, 8'h01);
        chk("R8 force before any match uses hold", wave_out, 0);
        wr(3'd0, 8'd0);
        ticks(4);
        chk("R7 toggle on match", wave_out, 1);
        rd(3'd0, v); chk("R11 count cleared with toggle", v, 0);
        wr(3'd4, 8'h03);
        wr(3'd3, 8'h01);
        chk("R9 force toggles", wave_out, 0);
        rd(3'd4, v); chk("R9 force sets no flag", v, 0);
        rd(3'd0, v); chk("R9 force keeps count", v, 0);
        wr(3'd2, 8'h0A);                          // CTC, clear
        wr(3'd3, 8'h01);
        chk("R8 force still uses toggle", wave_out, 1);
        ticks(4);
        chk("R7 clear on match", wave_out, 0);
        wr(3'd2, 8'h0E);                          // CTC, set
        ticks(4);
        chk("R7 set on match", wave_out, 1);
        rd(3'd0, v); chk("R11 count cleared with set", v, 0);
        wr(3'd2, 8'h02);                          // CTC, hold
        ticks(4);
        chk("R7 hold on match", wave_out, 1);
        wr(3'd3, 8'h01);
        chk("R9 force with hold", wave_out, 1);
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_tick_gate();
        t_wrap();
        t_ctc();
        t_wave();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule